// File: doc/BRIEF.md
# Barrel Shifter with Rotate-Through-Carry

This block is a purely combinational 32-bit shifter that prepares the second operand of an integer ALU. It takes the operand, a two-bit shift kind, a shift count and the current carry flag, and returns the shifted operand together with the carry the shifter produces. Four shift kinds are offered: logical left, logical right, arithmetic right and rotate right. A separate select turns the unit into a single-position rotate through the carry flag, treating flag and operand as one 33-bit ring.

The unit sits between operand decode and the ALU. The decode logic supplies a count that is already resolved, and the ALU chooses whether to use the produced carry. The unit holds no state and has no clock. A count of zero passes the operand and the incoming carry through unchanged. A count of exactly the word width follows well-defined rules for each kind. Counts beyond the word width behave as a count equal to the word width.

Top module: `barrel_shift_unit`

## Requirements
- R1: With kind 2'b00 (logical left) and count n from 1 to 31, the result is the operand moved n places toward bit 31 with zeros entering at bit 0, and the carry out is operand bit 32-n.
- R2: With kind 2'b01 (logical right) and count n from 1 to 31, the result is the operand moved n places toward bit 0 with zeros entering at bit 31, and the carry out is operand bit n-1.
- R3: With kind 2'b10 (arithmetic right) and count n from 1 to 31, vacated upper positions take copies of operand bit 31, and the carry out is operand bit n-1.
- R4: With kind 2'b11 (rotate right) and count n from 1 to 31, bits leaving bit 0 re-enter at bit 31, and the carry out equals result bit 31.
- R5: When the extend select is 1, the result is {carry in, operand[31:1]} and the carry out is operand bit 0, whatever the kind and the count.
- R6: With the extend select at 0 and a count of 0, the result equals the operand and the carry out equals the carry in, for every kind.
- R7: At a count of 32: logical left gives 0 with carry out operand bit 0; logical right gives 0 with carry out operand bit 31; arithmetic right gives 32 copies of bit 31 with that bit as carry out; rotate right returns the operand with carry out operand bit 31.
- R8: Any count from 33 to 63 gives exactly the result and carry out of a count of 32 with the same kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_in | input | 32 | Operand to shift |
| kind_in | input | 2 | Shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_in | input | 6 | Shift count, 0 to 63 |
| ext_in | input | 1 | Select the one-place rotate through carry |
| cin | input | 1 | Current carry flag |
| res_out | output | 32 | Shifted operand |
| cout | output | 1 | Carry produced by the shifter |

## Verification
The cases that are hardest to reach are at the ends of the count range. These are the count of zero, where the carry must come from the flag and not from the operand, and counts of 32 and above, where the internal rotate distance wraps to zero and only the masking and carry selection give the right answer. The stimulus sweeps every count from 0 to 63 for each kind. It does so with both carry-in values and with operands whose end bits and sign bit differ. Each result is compared against a bench model that shifts one place at a time.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/bsh_rotator.sv
// Logarithmic right rotator: one stage per bit of the rotate distance.
module bsh_rotator #(
  parameter int W  = 32,
  localparam int LG = $clog2(W)
) (
  input  logic [W-1:0]  data_in,
  input  logic [LG-1:0] dist_in,
  output logic [W-1:0]  data_out
);
  logic [W-1:0] stage [LG+1];

  assign stage[0] = data_in;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = dist_in[s]
      ? {stage[s][STEP-1:0], stage[s][W-1:STEP]}
      : stage[s];
  end

  assign data_out = stage[LG];
endmodule

// File: rtl/bsh_mask_gen.sv
// Marks which result positions hold rotated operand bits and which take fill.
module bsh_mask_gen
  import bsh_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W) + 1
) (
  input  shift_kind_e   kind_in,
  input  logic [AW-1:0] cnt_in,
  output logic [W-1:0]  keep_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [AW:0] POS = (AW+1)'(i);
    always_comb begin
      unique case (kind_in)
        SH_LSL:  keep_out[i] = (POS >= {1'b0, cnt_in});
        SH_LSR,
        SH_ASR:  keep_out[i] = ((POS + {1'b0, cnt_in}) < (AW+1)'(W));
        default: keep_out[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bsh_carry_sel.sv
// Picks the last operand bit pushed out by a shift of cnt_in places (cnt_in >= 1).
module bsh_carry_sel
  import bsh_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W) + 1,
  localparam int LG = $clog2(W)
) (
  input  logic [W-1:0]  data_in,
  input  shift_kind_e   kind_in,
  input  logic [AW-1:0] cnt_in,
  output logic          carry_out
);
  logic [AW-1:0] idx_w;
  logic [LG-1:0] idx;

  always_comb begin
    if (kind_in == SH_LSL) idx_w = AW'(W) - cnt_in;
    else                   idx_w = cnt_in - AW'(1);
    idx       = idx_w[LG-1:0];
    carry_out = data_in[idx];
  end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bsh_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W) + 1,
  localparam int LG = $clog2(W)
) (
  input  logic [W-1:0]  opnd_in,
  input  logic [1:0]    kind_in,
  input  logic [AW-1:0] amt_in,
  input  logic          ext_in,
  input  logic          cin,
  output logic [W-1:0]  res_out,
  output logic          cout
);
  shift_kind_e   kind;
  logic [AW-1:0] cnt;
  logic [LG-1:0] rot_dist;
  logic [AW-1:0] lsl_dist;
  logic [W-1:0]  rotated;
  logic [W-1:0]  keep;
  logic [W-1:0]  shifted;
  logic          fill_bit;
  logic          shift_carry;

  // Counts beyond the word width saturate at the word width.
  always_comb begin
    kind     = shift_kind_e'(kind_in);
    cnt      = (amt_in > AW'(W)) ? AW'(W) : amt_in;
    lsl_dist = AW'(W) - cnt;
    rot_dist = (kind == SH_LSL) ? lsl_dist[LG-1:0] : cnt[LG-1:0];
  end

  bsh_rotator #(.W(W)) u_rot (
    .data_in  (opnd_in),
    .dist_in  (rot_dist),
    .data_out (rotated)
  );

  bsh_mask_gen #(.W(W)) u_mask (
    .kind_in  (kind),
    .cnt_in   (cnt),
    .keep_out (keep)
  );

  bsh_carry_sel #(.W(W)) u_csel (
    .data_in   (opnd_in),
    .kind_in   (kind),
    .cnt_in    (cnt),
    .carry_out (shift_carry)
  );

  always_comb begin
    fill_bit = (kind == SH_ASR) ? opnd_in[W-1] : 1'b0;
    shifted  = (rotated & keep) | ({W{fill_bit}} & ~keep);
  end

  always_comb begin
    if (ext_in) begin
      res_out = {cin, opnd_in[W-1:1]};
      cout    = opnd_in[0];
    end else if (cnt == '0) begin
      res_out = opnd_in;
      cout    = cin;
    end else begin
      res_out = shifted;
      cout    = shift_carry;
    end
  end
endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
  parameter int W  = 32,
  localparam int AW = $clog2(W) + 1
) (
  input logic [W-1:0]  opnd_in,
  input logic [1:0]    kind_in,
  input logic [AW-1:0] amt_in,
  input logic          ext_in,
  input logic          cin,
  input logic [W-1:0]  res_out,
  input logic          cout
);
  always_comb begin
    // R5
    rrx_ring_chk: assert (!ext_in || (res_out == {cin, opnd_in[W-1:1]} && cout == opnd_in[0]));
    // R6
    zero_pass_chk: assert (ext_in || amt_in != '0 || (res_out == opnd_in && cout == cin));
    // R1
    lsl_fill_chk: assert (ext_in || amt_in == '0 || kind_in != 2'd0 || res_out[0] == 1'b0);
    // R2
    lsr_fill_chk: assert (ext_in || amt_in == '0 || kind_in != 2'd1 || res_out[W-1] == 1'b0);
    // R3
    asr_sign_chk: assert (ext_in || kind_in != 2'd2 || res_out[W-1] == opnd_in[W-1]);
    // R4
    ror_carry_chk: assert (ext_in || amt_in == '0 || kind_in != 2'd3 || cout == res_out[W-1]);
    // R4
    ror_weight_chk: assert (ext_in || kind_in != 2'd3 || $countones(res_out) == $countones(opnd_in));
  end
endmodule

bind barrel_shift_unit bsh_checker #(.W(W)) u_chk (
  .opnd_in (opnd_in),
  .kind_in (kind_in),
  .amt_in  (amt_in),
  .ext_in  (ext_in),
  .cin     (cin),
  .res_out (res_out),
  .cout    (cout)
);

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;
  logic        clk;
  logic [31:0] opnd;
  logic [1:0]  kind;
  logic [5:0]  amt;
  logic        ext;
  logic        c_in;
  logic [31:0] res;
  logic        c_out;
  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  barrel_shift_unit u_barrel_shift_unit (
    .opnd_in (opnd), .kind_in (kind), .amt_in (amt),
    .ext_in (ext), .cin (c_in), .res_out (res), .cout (c_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 200000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // Model: one place per step, starting from the incoming carry.
  function automatic logic [32:0] model(logic [31:0] x, logic [1:0] k, int n, logic e, logic ci);
    logic [31:0] v = x;
    logic c = ci;
    if (e) return {x[0], ci, x[31:1]};
    if (n > 32) n = 32;
    for (int j = 0; j < n; j++) begin
      case (k)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic chk(string req, logic [31:0] er, logic ec);
    n_checks++;
    if (res !== er || c_out !== ec) begin
      n_fail++;
      $display("FAIL %s: got res=%h c=%b expected res=%h c=%b (opnd=%h kind=%0d amt=%0d ext=%b cin=%b)",
               req, res, c_out, er, ec, opnd, kind, amt, ext, c_in);
    end
  endtask

  task automatic apply(string req, logic [31:0] x, logic [1:0] k, int n, logic e, logic ci);
    logic [32:0] m;
    @(negedge clk);
    opnd = x; kind = k; amt = 6'(n); ext = e; c_in = ci;
    #5;
    m = model(x, k, n, e, ci);
    chk(req, m[31:0], m[32]);
  endtask

  task automatic t_idle;  // R6 with every input at zero
    @(negedge clk);
    #5;
    chk("R6 idle", 32'h0, 1'b0);
  endtask

  task automatic t_lsl;
    apply("R1", 32'h8000_0001, 2'd0, 1, 0, 0);
    apply("R1", 32'h1234_5678, 2'd0, 4, 0, 1);
    apply("R1", 32'h0000_0003, 2'd0, 31, 0, 0);
  endtask

  task automatic t_lsr;
    apply("R2", 32'h8000_0001, 2'd1, 1, 0, 0);
    apply("R2", 32'hF0F0_0F0F, 2'd1, 8, 0, 0);
    apply("R2", 32'hC000_0000, 2'd1, 31, 0, 1);
  endtask

  task automatic t_asr;
    apply("R3", 32'h8000_0000, 2'd2, 4, 0, 0);
    apply("R3", 32'h7FFF_FFFF, 2'd2, 16, 0, 1);
    apply("R3", 32'h9000_0001, 2'd2, 31, 0, 0);
  endtask

  task automatic t_ror;
    apply("R4", 32'h0000_0001, 2'd3, 1, 0, 0);
    apply("R4", 32'h1234_5678, 2'd3, 12, 0, 0);
    apply("R4", 32'h8000_0000, 2'd3, 31, 0, 1);
  endtask

  task automatic t_rrx;
    apply("R5", 32'h0000_0001, 2'd0, 7, 1, 1);
    apply("R5", 32'hFFFF_FFFE, 2'd2, 0, 1, 0);
    apply("R5", 32'h8000_0003, 2'd3, 40, 1, 0);
  endtask

  task automatic t_zero;
    for (int k = 0; k < 4; k++) begin
      apply("R6", 32'hDEAD_BEEF, 2'(k), 0, 0, 1);
      apply("R6", 32'h8000_0001, 2'(k), 0, 0, 0);
    end
  endtask

  task automatic t_full;
    apply("R7", 32'h0000_0001, 2'd0, 32, 0, 0);
    apply("R7", 32'h8000_0000, 2'd1, 32, 0, 0);
    apply("R7", 32'h8000_0000, 2'd2, 32, 0, 0);
    apply("R7", 32'h4000_0001, 2'd2, 32, 0, 1);
    apply("R7", 32'hA5A5_5A5A, 2'd3, 32, 0, 0);
  endtask

  task automatic t_over;
    for (int k = 0; k < 4; k++) begin
      apply("R8", 32'h8000_0001, 2'(k), 33, 0, 0);
      apply("R8", 32'h7FFF_FFFE, 2'(k), 63, 0, 1);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'h1234_5678, 32'hC3A5_0F96};
    string tags [4] = '{"R1 sweep", "R2 sweep", "R3 sweep", "R4 sweep"};
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 64; n++)
        for (int p = 0; p < 4; p++)
          apply(tags[k], pats[p], 2'(k), n, 1'b0, 1'(p));
  endtask

  initial begin
    opnd = '0; kind = '0; amt = '0; ext = 1'b0; c_in = 1'b0;
    t_idle();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_rrx();
    t_zero();
    t_full();
    t_over();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule